// File: doc/BRIEF.md
# I2C Controller Host Register Block

This block is the byte-wide register file that sits between a host bus and an I2C byte engine working in controller mode. Software uses it to set the serial clock prescaler, to enable the core and its interrupt, to load a byte for transmission and to issue commands such as start, stop, read and write. It also reads back the received byte and the status. The serial timing and the shift logic live in a separate engine. This block drives that engine with one-cycle command strobes and level configuration, and takes back status levels, a received byte and a completion pulse.

Some offsets reach different registers depending on direction. Offset 3 is transmit data on a write and receive data on a read. Offset 4 is the command register on a write and the status register on a read.

The prescaler can only be written while the core is disabled. Its value is the peripheral clock divided by five times the desired serial clock rate, minus one, which allows rates up to 400 kHz. The interrupt flag is set by the engine and is cleared only by a command write with its acknowledge bit set.

Top module: `i2c_host_regs`

## Requirements
- R1: After reset the control register reads 0x00, the prescaler reads 0xFFFF (offset 0 and offset 1 both read 0xFF), the interrupt flag is clear, `irq` is low and every command strobe is low.
- R2: While control bit 7 (enable) is 0, a write to offset 0 loads prescaler bits 7:0 and a write to offset 1 loads bits 15:8. Both bytes read back at the same offsets and appear on `eng_prescale` from the cycle after the write.
- R3: While control bit 7 is 1, writes to offset 0 and offset 1 are ignored, so the prescaler readback and `eng_prescale` keep their old value.
- R4: Offset 2 is the control register. Bit 7 is core enable, bit 6 is interrupt enable and bit 5 selects controller mode. Only bits 7:5 are stored, bits 4:0 read as 0, and bits 7 and 5 drive `eng_enable` and `eng_ctrl_mode`.
- R5: A write to offset 3 loads the transmit byte driven on `eng_txd`. A read of offset 3 returns the byte captured from `eng_rxd` in the cycle `eng_done` was high.
- R6: A write to offset 4 issues command bits START=7, STOP=6, READ=5 and WRITE=4 as strobes on `eng_start`, `eng_stop`, `eng_read` and `eng_write`. Each strobe is high for exactly the one cycle after the write edge. Bit 3 (ACK) is held on `eng_ack` until the next command write.
- R7: A read of offset 4 returns the status byte: bit 7 no-acknowledge, bit 6 bus busy, bit 5 arbitration lost, bit 1 transfer in progress, bit 0 interrupt flag, and 0 in bits 4:2. Reading it changes no state.
- R8: A cycle with `eng_done` high sets the interrupt flag. A command write with bit 0 set clears it. When both happen in the same cycle, the flag stays set.
- R9: `irq` is a level equal to the interrupt flag ANDed with control bit 6.
- R10: Reads of offsets 5 to 7 return 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe for the current offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the current offset (combinational) |
| eng_prescale | output | 16 | Prescaler value to the engine |
| eng_enable | output | 1 | Core enable level |
| eng_ctrl_mode | output | 1 | Controller mode select level |
| eng_txd | output | 8 | Byte to transmit |
| eng_start | output | 1 | Start command strobe |
| eng_stop | output | 1 | Stop command strobe |
| eng_read | output | 1 | Read command strobe |
| eng_write | output | 1 | Write command strobe |
| eng_ack | output | 1 | Acknowledge bit held from the last command |
| eng_done | input | 1 | Engine completion pulse |
| eng_rxd | input | 8 | Received byte, valid with eng_done |
| eng_nack | input | 1 | No-acknowledge seen |
| eng_busy | input | 1 | Bus busy |
| eng_arb_lost | input | 1 | Arbitration lost |
| eng_tip | input | 1 | Transfer in progress |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check on every cycle that each command strobe lasts one cycle and that the prescaler stays stable while the core is enabled. They also check that a completion pulse sets the flag, that an acknowledge clears it unless a completion arrives in the same cycle, and that `irq` is never high without the flag. The bench scenarios are needed for what the assertions do not cover: the offset decode with different registers on read and write, the masking of the control bits, the bit positions of the status byte, the capture of the received byte, the unmapped offsets, and the absence of side effects on a status read. These are checked through the register interface.

// File: rtl/i2c_host_regs.sv
module i2c_host_regs #(
  parameter int ADDR_W = 3,
  parameter logic [15:0] PRESCALE_RST = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic [15:0]       eng_prescale,
  output logic              eng_enable,
  output logic              eng_ctrl_mode,
  output logic [7:0]        eng_txd,
  output logic              eng_start,
  output logic              eng_stop,
  output logic              eng_read,
  output logic              eng_write,
  output logic              eng_ack,
  input  logic              eng_done,
  input  logic [7:0]        eng_rxd,
  input  logic              eng_nack,
  input  logic              eng_busy,
  input  logic              eng_arb_lost,
  input  logic              eng_tip,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_PRE_LO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_PRE_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_CTRL   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_DATA   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFS_CMD    = ADDR_W'(4);

  logic [15:0] pre_q;
  logic [2:0]  ctrl_q;
  logic [7:0]  tx_q, rx_q;
  logic [3:0]  strobe_q;
  logic        ack_q, if_q;

  wire wr_pre_lo = wr_en && addr == OFS_PRE_LO && !ctrl_q[2];
  wire wr_pre_hi = wr_en && addr == OFS_PRE_HI && !ctrl_q[2];
  wire wr_ctrl   = wr_en && addr == OFS_CTRL;
  wire wr_data_r = wr_en && addr == OFS_DATA;
  wire wr_cmd    = wr_en && addr == OFS_CMD;
  wire if_clear  = wr_cmd && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= PRESCALE_RST;
      ctrl_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      strobe_q <= '0;
      ack_q    <= 1'b0;
      if_q     <= 1'b0;
    end else begin
      if (wr_pre_lo) pre_q[7:0]  <= wr_data;
      if (wr_pre_hi) pre_q[15:8] <= wr_data;
      if (wr_ctrl)   ctrl_q      <= wr_data[7:5];
      if (wr_data_r) tx_q        <= wr_data;
      if (eng_done)  rx_q        <= eng_rxd;
      strobe_q <= wr_cmd ? wr_data[7:4] : 4'b0000;
      if (wr_cmd)    ack_q       <= wr_data[3];
      if (eng_done)      if_q <= 1'b1;
      else if (if_clear) if_q <= 1'b0;
    end
  end

  assign eng_prescale  = pre_q;
  assign eng_enable    = ctrl_q[2];
  assign eng_ctrl_mode = ctrl_q[0];
  assign eng_txd       = tx_q;
  assign eng_start     = strobe_q[3];
  assign eng_stop      = strobe_q[2];
  assign eng_read      = strobe_q[1];
  assign eng_write     = strobe_q[0];
  assign eng_ack       = ack_q;
  assign irq           = if_q & ctrl_q[1];

  always_comb begin
    case (addr)
      OFS_PRE_LO: rd_data = pre_q[7:0];
      OFS_PRE_HI: rd_data = pre_q[15:8];
      OFS_CTRL:   rd_data = {ctrl_q, 5'b00000};
      OFS_DATA:   rd_data = rx_q;
      OFS_CMD:    rd_data = {eng_nack, eng_busy, eng_arb_lost, 3'b000, eng_tip, if_q};
      default:    rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/i2c_host_regs_chk.sv
module i2c_host_regs_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic [15:0]       eng_prescale,
  input logic              eng_enable,
  input logic              eng_start,
  input logic              eng_stop,
  input logic              eng_read,
  input logic              eng_write,
  input logic              eng_done,
  input logic              irq,
  input logic              if_flag
);
  wire cmd_wr = wr_en && addr == ADDR_W'(4);
  wire any_strobe = eng_start | eng_stop | eng_read | eng_write;

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (any_strobe && !cmd_wr) |=> !any_strobe);

  p_cmd_issues_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_data[7]) |=> eng_start);

  p_prescale_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_enable |=> $stable(eng_prescale));

  p_done_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> if_flag);

  p_ack_clears_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_data[0] && !eng_done) |=> !if_flag);

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> if_flag);
endmodule

bind i2c_host_regs i2c_host_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .eng_prescale(eng_prescale), .eng_enable(eng_enable),
  .eng_start(eng_start), .eng_stop(eng_stop), .eng_read(eng_read),
  .eng_write(eng_write), .eng_done(eng_done), .irq(irq), .if_flag(if_q)
);

// File: tb/i2c_host_regs_tb.sv
module i2c_host_regs_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = '0;
  logic wr_en = 0;
  logic [7:0] wr_data = '0, rd_data, eng_txd, eng_rxd = '0;
  logic [15:0] eng_prescale;
  logic eng_enable, eng_ctrl_mode, eng_start, eng_stop, eng_read, eng_write, eng_ack, irq;
  logic eng_done = 0, eng_nack = 0, eng_busy = 0, eng_arb_lost = 0, eng_tip = 0;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  i2c_host_regs u_dut (.*);

  // {offset, write data, expected read at the same offset}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {3'd0, 8'h34, 8'h34},  // R2
    {3'd1, 8'h12, 8'h12},  // R2
    {3'd2, 8'hFF, 8'hE0},  // R4
    {3'd0, 8'h99, 8'h34},  // R3
    {3'd1, 8'h88, 8'h12},  // R3
    {3'd2, 8'h20, 8'h20},  // R4
    {3'd0, 8'hC7, 8'hC7},  // R2
    {3'd3, 8'hA5, 8'h00},  // R5
    {3'd5, 8'h77, 8'h00},  // R10
    {3'd7, 8'h11, 8'h00}   // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd0, v); chk("R1 pre lo", v, 8'hFF);
    rd(3'd1, v); chk("R1 pre hi", v, 8'hFF);
    rd(3'd2, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 irq/strobes", {irq, eng_start, eng_stop, eng_read, eng_write}, 5'd0);
    rd(3'd4, v); chk("R1 flag", v[0], 1'b0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], v);
      chk($sformatf("vector %0d", i), v, VEC[i][7:0]);
    end
    chk("R2 eng_prescale", eng_prescale, 16'h12C7);
    chk("R5 eng_txd", eng_txd, 8'hA5);
    chk("R4 mode level", {eng_enable, eng_ctrl_mode}, 2'b01);
    rd(3'd2, v); chk("R10 ctrl untouched", v, 8'h20);

    // R3: enable then try both bytes
    wr(3'd2, 8'hA0);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    chk("R3 eng_prescale locked", eng_prescale, 16'h12C7);

    // R6: START|WRITE|ACK
    wr(3'd4, 8'h98);
    chk("R6 strobes", {eng_start, eng_stop, eng_read, eng_write, eng_ack}, 5'b10011);
    @(negedge clk);
    chk("R6 self-clear", {eng_start, eng_stop, eng_read, eng_write, eng_ack}, 5'b00001);
    wr(3'd4, 8'h60);
    chk("R6 stop/read", {eng_start, eng_stop, eng_read, eng_write, eng_ack}, 5'b01100);

    // R8/R5: completion with received byte, interrupt disabled
    eng_rxd = 8'h5A; eng_done = 1; @(negedge clk); eng_done = 0;
    rd(3'd4, v); chk("R8 flag set", v[0], 1'b1);
    chk("R9 irq masked", irq, 1'b0);
    rd(3'd3, v); chk("R5 rx byte", v, 8'h5A);
    wr(3'd2, 8'hE0);
    chk("R9 irq level", irq, 1'b1);

    // R7: status layout and no side effect
    eng_nack = 1; eng_busy = 1; eng_tip = 1;
    rd(3'd4, v); chk("R7 status", v, 8'hC3);
    @(negedge clk);
    rd(3'd4, v); chk("R7 no side effect", v, 8'hC3);
    eng_nack = 0; eng_busy = 0; eng_tip = 0; eng_arb_lost = 1;
    rd(3'd4, v); chk("R7 arb lost", v, 8'h21);
    eng_arb_lost = 0;

    // R8: ack clears
    wr(3'd4, 8'h01);
    rd(3'd4, v); chk("R8 ack clears", v[0], 1'b0);
    chk("R9 irq drops", irq, 1'b0);

    // R8: set wins over clear in the same cycle
    @(negedge clk); addr = 3'd4; wr_data = 8'h01; wr_en = 1; eng_done = 1;
    @(negedge clk); wr_en = 0; eng_done = 0;
    rd(3'd4, v); chk("R8 set wins", v[0], 1'b1);
    chk("R9 irq with collision", irq, 1'b1);

    // R3 -> R2: disabling unlocks the prescaler
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h3C);
    chk("R2 after disable", eng_prescale, 16'h3CC7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule